// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block performs one arithmetic or logical operation per accepted request on two byte operands and keeps four status flags (carry, zero, sign, overflow) in a register. A request is taken on a rising clock edge when the valid input is high. The operation is chosen by a 3-bit code. Add, subtract and bitwise AND return a result with a one-cycle write-enable pulse. Compare and test do the same work as subtract and AND respectively, but they only refresh the flags. The result register and the write-enable stay untouched for those two operations.

Carry follows the convention where a subtraction reports the raw unsigned borrow, not its inverse. The logical operations clear carry and overflow. Overflow is reported separately from carry, so a consumer can treat the same bits as signed or unsigned values.

The reset input is asynchronous and active low. Its release is synchronised to the clock inside the block, so the registers leave reset two clock edges after the input rises.

Top module: `byte_alu`

## Requirements
- R1: While reset is asserted and until the first accepted request, result_o is 0x00, wr_en_o is 0 and all four flags are 0.
- R2: Code 0 (ADD) produces A+B modulo 256 on result_o. Carry is the carry out of bit 7, so 0xFF+0x01 gives 0x00 with carry 1.
- R3: Code 1 (SUB) and code 3 (CMP) compute A−B. Carry is 1 exactly when B is larger than A as unsigned values: 0x05−0x07 gives carry 1, and 0x06−0x05 gives carry 0.
- R4: For ADD, overflow is 1 exactly when A and B share a sign bit and bit 7 of the sum differs from it. For example, 0x7F+0x7F gives 0xFE with overflow 1 and carry 0.
- R5: For SUB and CMP, overflow is 1 exactly when the sign bits of A and B differ and bit 7 of the difference differs from that of A. For example, 0x05−0x07 gives overflow 0, and 0x80−0x01 gives overflow 1.
- R6: For every accepted operation, zero is 1 exactly when the 8-bit value the operation computed is 0x00.
- R7: For every accepted operation, sign equals bit 7 of the 8-bit value the operation computed.
- R8: Code 2 (AND) and code 4 (TEST) compute A AND B. They force carry and overflow to 0.
- R9: CMP and TEST never raise wr_en_o, and they leave result_o unchanged.
- R10: In a cycle with valid_i low, the flags and result_o hold their values and wr_en_o is 0.
- R11: Codes 5, 6 and 7 with valid_i high have no effect: the flags and result_o hold, and wr_en_o stays 0.
- R12: An accepted request appears on the outputs after exactly one rising edge. wr_en_o is high for that one cycle only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request strobe, sampled on the rising edge |
| op_i | input | 3 | Operation code: 0 ADD, 1 SUB, 2 AND, 3 CMP, 4 TEST |
| a_i | input | 8 | Operand A (minuend for SUB/CMP) |
| b_i | input | 8 | Operand B |
| result_o | output | 8 | Registered result of the last ADD, SUB or AND |
| wr_en_o | output | 1 | One-cycle pulse when result_o was just written |
| carry_o | output | 1 | Carry / borrow flag |
| zero_o | output | 1 | Zero flag |
| sign_o | output | 1 | Sign flag |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
The arithmetic paths are driven with pairs chosen to separate carry from overflow:
- a borrow without signed overflow (0x05−0x07);
- a signed overflow without carry (0x7F+0x7F);
- both carry and zero together (0xFF+0x01);
- a sign-crossing subtract (0x80−0x01).

Logical operations are tried with disjoint masks, which give zero, and with a negative operand tested against itself. These cases show that carry and overflow are forced to 0 while zero and sign still follow the value.

A compare or test placed directly after an add shows whether the result register is protected. Idle cycles and the unused codes 5 to 7 show whether the flags hold. A sweep of computed operand pairs over all five codes then checks every output against an independent model.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_CMP  = 3'd3,
    OP_TEST = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic carry;
    logic zero;
    logic sign;
    logic ovf;
  } alu_flags_t;

  typedef struct packed {
    logic legal;      // code maps to an operation
    logic use_logic;  // AND path instead of adder
    logic subtract;   // adder runs A - B
    logic writes;     // result is written back
  } alu_ctl_t;

endpackage

// File: rtl/balu_rst_sync.sv
module balu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/balu_decode.sv
module balu_decode
  import byte_alu_pkg::*;
(
  input  logic [2:0] op_i,
  output alu_ctl_t   ctl_o
);

  always_comb begin
    ctl_o = '0;
    case (op_i)
      OP_ADD: begin
        ctl_o.legal  = 1'b1;
        ctl_o.writes = 1'b1;
      end
      OP_SUB: begin
        ctl_o.legal    = 1'b1;
        ctl_o.subtract = 1'b1;
        ctl_o.writes   = 1'b1;
      end
      OP_CMP: begin
        ctl_o.legal    = 1'b1;
        ctl_o.subtract = 1'b1;
      end
      OP_AND: begin
        ctl_o.legal     = 1'b1;
        ctl_o.use_logic = 1'b1;
        ctl_o.writes    = 1'b1;
      end
      OP_TEST: begin
        ctl_o.legal     = 1'b1;
        ctl_o.use_logic = 1'b1;
      end
      default: ctl_o = '0;
    endcase
  end

endmodule

// File: rtl/balu_addsub.sv
module balu_addsub #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             subtract_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             ovf_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   total;

  always_comb begin
    b_eff   = b_i ^ {WIDTH{subtract_i}};
    total   = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, subtract_i};
    sum_o   = total[MSB:0];
    // raw borrow on subtract: inverted carry out of the top bit
    carry_o = total[WIDTH] ^ subtract_i;
    ovf_o   = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
  end

endmodule

// File: rtl/balu_flaggen.sv
module balu_flaggen
  import byte_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_ctl_t         ctl_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] sum_i,
  input  logic             add_carry_i,
  input  logic             add_ovf_i,
  output logic [WIDTH-1:0] value_o,
  output alu_flags_t       flags_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] and_val;

  always_comb begin
    and_val = a_i & b_i;
    if (ctl_i.use_logic) begin
      value_o       = and_val;
      flags_o.carry = 1'b0;
      flags_o.ovf   = 1'b0;
    end else begin
      value_o       = sum_i;
      flags_o.carry = add_carry_i;
      flags_o.ovf   = add_ovf_i;
    end
    flags_o.zero = (value_o == '0);
    flags_o.sign = value_o[MSB];
  end

endmodule

// File: rtl/balu_statereg.sv
module balu_statereg
  import byte_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  alu_ctl_t         ctl_i,
  input  logic [WIDTH-1:0] value_i,
  input  alu_flags_t       flags_i,
  output logic [WIDTH-1:0] result_q,
  output logic             wr_q,
  output alu_flags_t       flags_q
);

  localparam int MSB = WIDTH - 1;

  logic             load_flags;
  logic             load_res;
  alu_flags_t       flags_d;
  logic [WIDTH-1:0] result_d;

  always_comb begin
    load_flags = valid_i && ctl_i.legal;
    load_res   = load_flags && ctl_i.writes;
    flags_d    = load_flags ? flags_i : flags_q;
    result_d   = load_res ? value_i : result_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q  <= '0;
      result_q <= '0;
      wr_q     <= 1'b0;
    end else begin
      flags_q  <= flags_d;
      result_q <= result_d;
      wr_q     <= load_res;
    end
  end

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(flags_q) && $stable(result_q) && !wr_q); // R10

  AST_NO_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ctl_i.legal && !ctl_i.writes) |=> !wr_q && $stable(result_q)); // R9

  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> (flags_q.zero == (result_q == '0))); // R6

  AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> (flags_q.sign == result_q[MSB])); // R7

  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> $past(valid_i)); // R12

endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] result_o,
  output logic             wr_en_o,
  output logic             carry_o,
  output logic             zero_o,
  output logic             sign_o,
  output logic             ovf_o
);

  localparam int MSB = WIDTH - 1;

  logic             rst_s;
  alu_ctl_t         ctl;
  logic [WIDTH-1:0] sum;
  logic             add_carry;
  logic             add_ovf;
  logic [WIDTH-1:0] value;
  alu_flags_t       flags_nxt;
  alu_flags_t       flags_q;

  balu_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s)
  );

  balu_decode u_dec (
    .op_i  (op_i),
    .ctl_o (ctl)
  );

  balu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i        (a_i),
    .b_i        (b_i),
    .subtract_i (ctl.subtract),
    .sum_o      (sum),
    .carry_o    (add_carry),
    .ovf_o      (add_ovf)
  );

  balu_flaggen #(.WIDTH(WIDTH)) u_flags (
    .ctl_i       (ctl),
    .a_i         (a_i),
    .b_i         (b_i),
    .sum_i       (sum),
    .add_carry_i (add_carry),
    .add_ovf_i   (add_ovf),
    .value_o     (value),
    .flags_o     (flags_nxt)
  );

  balu_statereg #(.WIDTH(WIDTH)) u_state (
    .clk      (clk),
    .rst_n    (rst_s),
    .valid_i  (valid_i),
    .ctl_i    (ctl),
    .value_i  (value),
    .flags_i  (flags_nxt),
    .result_q (result_o),
    .wr_q     (wr_en_o),
    .flags_q  (flags_q)
  );

  assign carry_o = flags_q.carry;
  assign zero_o  = flags_q.zero;
  assign sign_o  = flags_q.sign;
  assign ovf_o   = flags_q.ovf;

  AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (!rst_s)
    (valid_i && (op_i == OP_AND || op_i == OP_TEST)) |=> !carry_o && !ovf_o); // R8

  AST_ADD_NO_OVF: assert property (@(posedge clk) disable iff (!rst_s)
    (valid_i && op_i == OP_ADD && a_i[MSB] != b_i[MSB]) |=> !ovf_o); // R4

  AST_SUB_NO_OVF: assert property (@(posedge clk) disable iff (!rst_s)
    (valid_i && (op_i == OP_SUB || op_i == OP_CMP) && a_i[MSB] == b_i[MSB]) |=> !ovf_o); // R5

  AST_SUB_BORROW: assert property (@(posedge clk) disable iff (!rst_s)
    (valid_i && (op_i == OP_SUB || op_i == OP_CMP)) |=> (carry_o == ($past(a_i) < $past(b_i)))); // R3

  AST_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_s)
    (valid_i && op_i > 3'd4) |=> $stable({carry_o, zero_o, sign_o, ovf_o}) && !wr_en_o); // R11

endmodule

// File: tb/byte_alu_test.sv
module byte_alu_test;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       valid_i;
  logic [2:0] op_i;
  logic [7:0] a_i;
  logic [7:0] b_i;
  logic [7:0] result_o;
  logic       wr_en_o;
  logic       carry_o;
  logic       zero_o;
  logic       sign_o;
  logic       ovf_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] res;
    logic       wr;
    logic       cf;
    logic       zf;
    logic       sf;
    logic       of;
    string      tag;
  } exp_t;

  exp_t sb_q[$];

  logic [7:0] m_res;
  logic       m_cf, m_zf, m_sf, m_of;

  byte_alu #(.WIDTH(8)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (valid_i),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .result_o (result_o),
    .wr_en_o  (wr_en_o),
    .carry_o  (carry_o),
    .zero_o   (zero_o),
    .sign_o   (sign_o),
    .ovf_o    (ovf_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {res,wr,cf,zf,sf,of} actual=%h_%b%b%b%b%b expected=%h_%b%b%b%b%b",
               tag, act[12:5], act[4], act[3], act[2], act[1], act[0],
               exp[12:5], exp[4], exp[3], exp[2], exp[1], exp[0]);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] op,
                       input logic [7:0] a, input logic [7:0] b, input string tag);
    logic [8:0] w;
    logic [7:0] r;
    logic       cf, of, upd, wr;
    exp_t       it;
    @(negedge clk);
    valid_i = v; op_i = op; a_i = a; b_i = b;
    upd = 1'b1; wr = 1'b0; r = '0; cf = 1'b0; of = 1'b0;
    case (op)
      3'd0: begin
        w = {1'b0, a} + {1'b0, b}; r = w[7:0]; cf = w[8];
        of = (a[7] == b[7]) && (r[7] != a[7]); wr = 1'b1;
      end
      3'd1, 3'd3: begin
        w = {1'b0, a} - {1'b0, b}; r = w[7:0]; cf = (a < b);
        of = (a[7] != b[7]) && (r[7] != a[7]); wr = (op == 3'd1);
      end
      3'd2, 3'd4: begin
        r = a & b; wr = (op == 3'd2);
      end
      default: upd = 1'b0;
    endcase
    if (v && upd) begin
      m_cf = cf; m_of = of; m_zf = (r == 8'h00); m_sf = r[7];
      if (wr) m_res = r;
    end
    it.res = m_res; it.wr = v && upd && wr;
    it.cf = m_cf; it.zf = m_zf; it.sf = m_sf; it.of = m_of; it.tag = tag;
    sb_q.push_back(it);
  endtask

  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      exp_t it;
      it = sb_q.pop_front();
      check(it.tag, {result_o, wr_en_o, carry_o, zero_o, sign_o, ovf_o},
            {it.res, it.wr, it.cf, it.zf, it.sf, it.of});
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; valid_i = 1'b0; op_i = '0; a_i = '0; b_i = '0;
    m_res = '0; m_cf = 0; m_zf = 0; m_sf = 0; m_of = 0;
    repeat (3) @(negedge clk);
    check("R1 during reset", {result_o, wr_en_o, carry_o, zero_o, sign_o, ovf_o}, 13'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", {result_o, wr_en_o, carry_o, zero_o, sign_o, ovf_o}, 13'd0);

    drive(1, 3'd4, 8'h0F, 8'h02, "R8 R9 TEST 0F,02");
    drive(1, 3'd3, 8'h06, 8'h05, "R3 CMP 06-05");
    drive(1, 3'd3, 8'h05, 8'h07, "R3 R5 CMP 05-07");
    drive(1, 3'd0, 8'h7F, 8'h7F, "R4 ADD 7F+7F");
    drive(0, 3'd1, 8'h00, 8'h00, "R12 R10 wr pulse ends");
    drive(1, 3'd0, 8'hFF, 8'h01, "R2 R6 ADD FF+01");
    drive(1, 3'd1, 8'h80, 8'h01, "R5 SUB 80-01");
    drive(1, 3'd1, 8'h00, 8'h01, "R3 R7 SUB 00-01");
    drive(1, 3'd3, 8'h10, 8'h10, "R9 R6 CMP equal keeps result");
    drive(1, 3'd2, 8'hF0, 8'h0F, "R8 R6 AND disjoint");
    drive(1, 3'd4, 8'h90, 8'h90, "R8 R7 TEST negative");
    drive(0, 3'd0, 8'h7F, 8'h7F, "R10 idle hold");
    drive(1, 3'd5, 8'h00, 8'h00, "R11 code 5");
    drive(1, 3'd6, 8'hFF, 8'h01, "R11 code 6");
    drive(1, 3'd7, 8'h80, 8'h01, "R11 code 7");
    drive(1, 3'd2, 8'hC3, 8'hA5, "R2 R8 AND writes");

    for (int i = 0; i < 60; i++) begin
      logic [7:0] a, b;
      a = 8'(i * 37 + 11);
      b = 8'(i * 91 + 5);
      drive(1, 3'(i % 5), a, b, "R2 R3 R4 R5 R6 R7 sweep");
    end
    drive(0, 3'd0, 8'h00, 8'h00, "R10 final idle");
    repeat (4) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule